// File: doc/BRIEF.md
# Windowed Receive Message Queue

This block sits between a CAN receive engine and the CPU bus of a controller. The engine hands over complete frames: an identifier word, a length code and eight data bytes. The block keeps up to four of them in arrival order. The CPU never addresses the individual slots. It reads the oldest pending frame through one fixed read window, which has an identifier register, a length register and two data registers. It then retires that frame by writing the key value 0xFF to a release register, and the window moves on to the next frame.

A control register enables the queue and reports whether anything is pending. Each stored frame sets a receive flag, and an enable mask routes that flag to an interrupt line. When a frame arrives and all four slots are occupied, the block sets an overrun error flag. A policy bit then decides the outcome:

- **Discard policy:** the new frame is dropped and the stored frames are kept.
- **Overwrite policy:** the new frame replaces the most recently stored one.

Clearing the enable bit throws away everything that is queued.

Top module: `rxq_window_fifo`

## Requirements
- R1: After reset the control register reads 0x80 (empty status at bit 7 set, enable at bit 0 clear). The interrupt status, error flag register and `irq` all read 0.
- R2: While the enable bit is 0, frames offered by the engine are not stored. The empty status stays 1 and the receive flag stays 0.
- R3: Frames are read through the window oldest first:
  - address 0 holds the identifier word unchanged (bit 31 extended-ID marker, bit 30 remote-request marker);
  - address 1 holds the length code in bits 3:0;
  - address 2 holds data bytes 0 to 3, with byte 0 in bits 7:0;
  - address 3 holds data bytes 4 to 7.
- R4: Writing 0xFF to the release register (address 5) retires the frame in the window and advances to the next one. Any other value written there has no effect.
- R5: A release write while the queue is empty has no effect. The queue stays empty, and the next frame stored is the one shown in the window.
- R6: Bit 7 of the control register (address 4) reads 1 exactly when no frame is pending.
- R7: Bit 4 of the interrupt status register (address 7) is set when a frame is stored. Writing that register with bit 4 at 0 clears the flag. Writing it with bit 4 at 1 leaves the flag unchanged.
- R8: `irq` follows interrupt status bit 4 masked by bit 4 of the interrupt enable register (address 6), with one cycle of latency.
- R9: With the policy bit (address 9, bit 0) at 1, a frame arriving at a full queue is discarded. The four stored frames remain, and bit 5 of the error flag register (address 8) is set.
- R10: With the policy bit at 0, a frame arriving at a full queue replaces the newest stored frame, and error flag bit 5 is set.
- R11: Writing 0 to the enable bit empties the queue, so the empty status reads 1.
- R12: Writing the error flag register with bit 5 at 0 clears the overrun flag.
- R13: A frame can arrive at a full queue in the same cycle as a release write. In that case the frame is accepted and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Engine offers a frame this cycle |
| rx_id | input | 32 | Identifier word of the offered frame |
| rx_dlc | input | 4 | Length code of the offered frame |
| rx_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| cpu_addr | input | 4 | Register address |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Read data, registered one cycle after the address |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest situation to reach from the ports is a frame arriving at a full queue in the very cycle the CPU retires an entry. The bench fills all four slots, then drives the engine strobe and the 0xFF release write on the same clock edge. It then walks the window to confirm the frame was accepted without an overrun. The two full-queue policies are reached by filling the queue and offering a fifth frame. The bench then reads every remaining entry in order, so a damaged or missing slot shows up as a wrong value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ID_W   = 32;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;

  localparam int FRAME_W = $bits(rx_frame_t);

  // register map
  localparam logic [ADDR_W-1:0] A_WIN_ID  = 4'd0;
  localparam logic [ADDR_W-1:0] A_WIN_DLC = 4'd1;
  localparam logic [ADDR_W-1:0] A_WIN_DLO = 4'd2;
  localparam logic [ADDR_W-1:0] A_WIN_DHI = 4'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd4;
  localparam logic [ADDR_W-1:0] A_RELEASE = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd6;
  localparam logic [ADDR_W-1:0] A_ISTAT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ERR     = 4'd8;
  localparam logic [ADDR_W-1:0] A_POLICY  = 4'd9;

  localparam int BIT_EN    = 0;
  localparam int BIT_EMPTY = 7;
  localparam int BIT_RXF   = 4;
  localparam int BIT_OVR   = 5;
  localparam int BIT_POL   = 0;

  localparam logic [7:0] RELEASE_KEY = 8'hFF;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  rx_frame_t       wr_frame,
  input  logic [AW-1:0]   rd_addr,
  output rx_frame_t       rd_frame
);
  logic [FRAME_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_frame;
  end

  assign rd_frame = rx_frame_t'(mem[rd_addr]);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          discard_mode,
  input  logic          frame_valid,
  input  logic          release_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          release_ok,
  output logic          stored,
  output logic          lost,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr;
  logic          full, accept, overwrite;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  always_comb begin
    full       = (count == FULL_CNT);
    empty      = (count == '0);
    release_ok = release_req && !empty && enable;
    accept     = enable && frame_valid && (!full || release_ok);
    lost       = enable && frame_valid && full && !release_ok;
    overwrite  = lost && !discard_mode;
    wr_en      = accept || overwrite;
    wr_addr    = accept ? wr_ptr : ptr_dec(wr_ptr);
    stored     = wr_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept)     wr_ptr <= ptr_inc(wr_ptr);
      if (release_ok) rd_ptr <= ptr_inc(rd_ptr);
      case ({accept, release_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  rx_frame_t         window,
  input  logic              empty,
  input  logic              stored,
  input  logic              lost,
  output logic              enable,
  output logic              discard_mode,
  output logic              ier_rx,
  output logic              isr_rx,
  output logic              err_ovr,
  output logic              release_req,
  output logic              irq
);
  logic wr_ctrl, wr_ien, wr_istat, wr_err, wr_pol;

  always_comb begin
    wr_ctrl     = cpu_we && (cpu_addr == A_CTRL);
    wr_ien      = cpu_we && (cpu_addr == A_IEN);
    wr_istat    = cpu_we && (cpu_addr == A_ISTAT);
    wr_err      = cpu_we && (cpu_addr == A_ERR);
    wr_pol      = cpu_we && (cpu_addr == A_POLICY);
    release_req = cpu_we && (cpu_addr == A_RELEASE) &&
                  (cpu_wdata[7:0] == RELEASE_KEY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable       <= 1'b0;
      discard_mode <= 1'b0;
      ier_rx       <= 1'b0;
      isr_rx       <= 1'b0;
      err_ovr      <= 1'b0;
      irq          <= 1'b0;
    end else begin
      if (wr_ctrl) enable       <= cpu_wdata[BIT_EN];
      if (wr_pol)  discard_mode <= cpu_wdata[BIT_POL];
      if (wr_ien)  ier_rx       <= cpu_wdata[BIT_RXF];
      if (stored)                              isr_rx <= 1'b1;
      else if (wr_istat && !cpu_wdata[BIT_RXF]) isr_rx <= 1'b0;
      if (lost)                                err_ovr <= 1'b1;
      else if (wr_err && !cpu_wdata[BIT_OVR])  err_ovr <= 1'b0;
      irq <= isr_rx && ier_rx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else begin
      cpu_rdata <= '0;
      case (cpu_addr)
        A_WIN_ID:  cpu_rdata <= window.id;
        A_WIN_DLC: cpu_rdata <= REG_W'(window.dlc);
        A_WIN_DLO: cpu_rdata <= window.data[31:0];
        A_WIN_DHI: cpu_rdata <= window.data[63:32];
        A_CTRL: begin
          cpu_rdata[BIT_EN]    <= enable;
          cpu_rdata[BIT_EMPTY] <= empty;
        end
        A_IEN:    cpu_rdata[BIT_RXF] <= ier_rx;
        A_ISTAT:  cpu_rdata[BIT_RXF] <= isr_rx;
        A_ERR:    cpu_rdata[BIT_OVR] <= err_ovr;
        A_POLICY: cpu_rdata[BIT_POL] <= discard_mode;
        default:  cpu_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxq_window_fifo.sv
module rxq_window_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_frame_t     in_frame, window;
  logic          wr_en, release_ok, release_req, stored, lost, empty;
  logic [AW-1:0] wr_addr, rd_ptr;
  logic [CW-1:0] count;
  logic          enable, discard_mode, ier_rx, isr_rx, err_ovr;

  assign in_frame = '{id: rx_id, dlc: rx_dlc, data: rx_data};

  rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_frame (in_frame),
    .rd_addr  (rd_ptr),
    .rd_frame (window)
  );

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .discard_mode (discard_mode),
    .frame_valid  (rx_valid),
    .release_req  (release_req),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .rd_ptr       (rd_ptr),
    .count        (count),
    .release_ok   (release_ok),
    .stored       (stored),
    .lost         (lost),
    .empty        (empty)
  );

  rxq_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_we       (cpu_we),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .window       (window),
    .empty        (empty),
    .stored       (stored),
    .lost         (lost),
    .enable       (enable),
    .discard_mode (discard_mode),
    .ier_rx       (ier_rx),
    .isr_rx       (isr_rx),
    .err_ovr      (err_ovr),
    .release_req  (release_req),
    .irq          (irq)
  );
endmodule

// File: rtl/rxq_window_fifo_chk.sv
module rxq_window_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          discard_mode,
  input logic          frame_valid,
  input logic          release_req,
  input logic          stored,
  input logic          lost,
  input logic [CW-1:0] count,
  input logic          ier_rx,
  input logic          isr_rx,
  input logic          err_ovr,
  input logic          irq
);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r7_store_sets_flag: assert property (@(posedge clk) disable iff (rst)
    stored |=> isr_rx);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !ier_rx |=> !irq);

  a_r9_discard_holds: assert property (@(posedge clk) disable iff (rst)
    (lost && discard_mode) |=> (count == CW'(DEPTH)) && err_ovr);

  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == '0));

  a_r5_empty_release: assert property (@(posedge clk) disable iff (rst)
    (release_req && count == '0 && !(enable && frame_valid)) |=> (count == '0));
endmodule

bind rxq_window_fifo rxq_window_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .discard_mode (discard_mode),
  .frame_valid  (rx_valid),
  .release_req  (release_req),
  .stored       (stored),
  .lost         (lost),
  .count        (count),
  .ier_rx       (ier_rx),
  .isr_rx       (isr_rx),
  .err_ovr      (err_ovr),
  .irq          (irq)
);

// File: tb/tb_rxq_window_fifo.sv
module tb_rxq_window_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [3:0]  cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rxq_window_fifo #(.DEPTH(4)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; cpu_wdata = '0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  function automatic logic [31:0] mk_id(input int k);
    return (k % 2 == 0) ? {3'b100, 29'(k * 4099 + 7)} : {2'b01, 30'(11'(k * 37 + 3)) << 18};
  endfunction

  function automatic logic [63:0] mk_data(input int k);
    return {8{8'(k + 8'h21)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [3:0] mk_dlc(input int k);
    return 4'((k * 3) % 9);
  endfunction

  task automatic push(input int k);
    rx_id = mk_id(k); rx_dlc = mk_dlc(k); rx_data = mk_data(k); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_window(input string tag, input int k);
    logic [31:0] v;
    reg_read(4'd0, v); chk({tag, " id"}, v, mk_id(k));
    reg_read(4'd1, v); chk({tag, " dlc"}, v, {28'b0, mk_dlc(k)});
    reg_read(4'd2, v); chk({tag, " data lo"}, v, mk_data(k)[31:0]);
    reg_read(4'd3, v); chk({tag, " data hi"}, v, mk_data(k)[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(4'd4, v); chk("R1 ctrl after reset", v, 32'h80);
    reg_read(4'd7, v); chk("R1 istat after reset", v, 32'h0);
    reg_read(4'd8, v); chk("R1 err after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    push(90); idle(1);
    reg_read(4'd4, v); chk("R2 empty while disabled", v, 32'h80);
    reg_read(4'd7, v); chk("R2 no flag while disabled", v, 32'h0);
  endtask

  task automatic t_release_empty;
    logic [31:0] v;
    reg_write(4'd5, 32'hFF);
    reg_read(4'd4, v); chk("R5 empty after idle release", v, 32'h81);
    push(1);
    reg_read(4'd4, v); chk("R6 nonempty after store", v, 32'h01);
    expect_window("R5 window after idle release", 1);
    reg_write(4'd5, 32'hFF);
    reg_read(4'd4, v); chk("R6 empty after last release", v, 32'h81);
    reg_write(4'd7, 32'h0);
  endtask

  task automatic t_order_irq;
    logic [31:0] v;
    push(2); push(3);
    expect_window("R3 oldest first", 2);
    reg_read(4'd7, v); chk("R7 flag set on store", v, 32'h10);
    chk("R8 irq with mask on", {31'b0, irq}, 32'h1);
    reg_write(4'd5, 32'h55);
    expect_window("R4 non-key write ignored", 2);
    reg_write(4'd5, 32'hFF);
    expect_window("R4 advance to second (remote frame)", 3);
    reg_write(4'd7, 32'h10);
    reg_read(4'd7, v); chk("R7 write one keeps flag", v, 32'h10);
    reg_write(4'd6, 32'h0);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    reg_write(4'd6, 32'h10);
    reg_write(4'd7, 32'h0);
    reg_read(4'd7, v); chk("R7 write zero clears flag", v, 32'h0);
    chk("R8 irq drops with flag", {31'b0, irq}, 32'h0);
    reg_write(4'd5, 32'hFF);
    reg_read(4'd4, v); chk("R6 empty after draining", v, 32'h81);
  endtask

  task automatic t_discard;
    logic [31:0] v;
    reg_write(4'd9, 32'h1);
    for (int k = 10; k < 15; k++) push(k);
    reg_read(4'd8, v); chk("R9 overrun flag set", v, 32'h20);
    for (int k = 10; k < 14; k++) begin
      expect_window("R9 stored entries intact", k);
      reg_write(4'd5, 32'hFF);
    end
    reg_read(4'd4, v); chk("R9 fifth frame dropped", v, 32'h81);
    reg_write(4'd8, 32'h0);
    reg_read(4'd8, v); chk("R12 overrun flag cleared", v, 32'h0);
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    reg_write(4'd9, 32'h0);
    for (int k = 20; k < 25; k++) push(k);
    reg_read(4'd8, v); chk("R10 overrun flag set", v, 32'h20);
    for (int k = 20; k < 23; k++) begin
      expect_window("R10 older entries kept", k);
      reg_write(4'd5, 32'hFF);
    end
    expect_window("R10 newest replaced", 24);
    reg_write(4'd5, 32'hFF);
    reg_read(4'd4, v); chk("R10 drained", v, 32'h81);
    reg_write(4'd8, 32'h0);
  endtask

  task automatic t_full_release;
    logic [31:0] v;
    reg_write(4'd9, 32'h1);
    for (int k = 30; k < 34; k++) push(k);
    rx_id = mk_id(34); rx_dlc = mk_dlc(34); rx_data = mk_data(34); rx_valid = 1'b1;
    cpu_addr = 4'd5; cpu_wdata = 32'hFF; cpu_we = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; cpu_we = 1'b0; cpu_wdata = '0;
    reg_read(4'd8, v); chk("R13 no overrun on simultaneous release", v, 32'h0);
    for (int k = 31; k < 35; k++) begin
      expect_window("R13 frame accepted", k);
      reg_write(4'd5, 32'hFF);
    end
  endtask

  task automatic t_flush;
    logic [31:0] v;
    push(40); push(41);
    reg_write(4'd4, 32'h0);
    reg_read(4'd4, v); chk("R11 flush on disable", v, 32'h80);
    reg_write(4'd4, 32'h1);
    reg_read(4'd4, v); chk("R11 still empty on re-enable", v, 32'h81);
    push(42);
    expect_window("R11 fresh frame after flush", 42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_disabled;
    reg_write(4'd4, 32'h1);
    reg_write(4'd6, 32'h10);
    t_release_empty;
    t_order_irq;
    t_discard;
    t_overwrite;
    t_full_release;
    t_flush;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule